// File: doc/BRIEF.md
# Double-Buffered Coefficient Memory Arbiter

This block shares a coefficient store between a host register port and the read port of a filter engine. The store has two banks, A and B. The host reaches them through two windows, where a window is picked by one select bit and a word inside it by an index. A small control register sets the operating mode, shows which bank the engine is using and takes swap requests. Two inputs come from outside the block: a processing-enabled level, which is the converter's power state, and a frame strobe.

In merged mode the two banks act as one coefficient space of twice the size. Whoever holds that space, the host or the engine, holds all of it. In ping-pong mode, once the engine is running, the engine reads one bank and the host edits the other. Both host windows then point at that idle bank. A swap request waits for the next frame strobe, so the bank change falls between frames and no frame sees a mix of old and new coefficients.

Top module: `coef_bank_arbiter`

## Requirements
- R1: After reset the control register reads 3'b000 and the host can access the coefficient store. Bit 2 is the ping-pong enable, bit 1 is the engine's bank (0 = A, 1 = B) and bit 0 is a pending swap.
- R2: In merged mode with the engine disabled, host window 0 reads and writes bank A and window 1 reads and writes bank B, with read data one cycle after the address. In this state the engine read data is zero.
- R3: In merged mode with the engine enabled, host reads return zero and host writes change nothing. The engine reads the merged space, where address MSB 0 selects bank A and 1 selects bank B, with a one-cycle latency.
- R4: A control write sets bit 2 only while the engine is disabled. While the engine is enabled, the value of bit 2 does not change.
- R5: In ping-pong mode with the engine disabled, each window maps to its own bank (0 to A, 1 to B) and the engine read data is zero.
- R6: In ping-pong mode with the engine enabled, the engine reads the bank shown by bit 1 and ignores its address MSB. Both host windows reach the other bank, so a word written through one window reads back through the other.
- R7: Writing 1 to bit 0 sets the pending flag. On the first frame strobe seen while the flag is set, bit 1 inverts and bit 0 clears, both visible in the cycle after the strobe.
- R8: A request written in the same cycle as a strobe does not swap at that strobe. With no strobes, a request stays pending.
- R9: A second request while one is pending is ignored, so one strobe gives exactly one bank change.
- R10: The first time the engine is enabled in ping-pong mode after reset, it reads bank A.
- R11: A swap request is ignored unless ping-pong mode is on and the engine is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_on | input | 1 | Engine enabled (converter powered) |
| frame_tick | input | 1 | One-cycle frame boundary strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data |
| ctl_rdata | output | 3 | Control register readback |
| cf_we | input | 1 | Host coefficient write strobe |
| cf_win | input | 1 | Host window select |
| cf_idx | input | IDX_W | Host word index |
| cf_wdata | input | WORD_W | Host write data |
| cf_rdata | output | WORD_W | Host read data, one cycle latency |
| eng_addr | input | IDX_W+1 | Engine address, MSB is the bank in merged mode |
| eng_rdata | output | WORD_W | Engine read data, one cycle latency |

## Verification
The hardest state to reach from the ports is two competing swap events. One is a request that arrives in the same cycle as a frame strobe. The other is a second request that arrives while a swap is already pending. In both cases a wrong design still changes banks, only one frame too early or twice, so the error is easy to miss. The bench first fills both banks with patterns that tell the banks apart. It then brings the engine up in ping-pong mode and drives the control write and the strobe together on one negative edge. After that it holds strobes off across a re-request and counts the bank changes through the engine's read data and bit 1.

// File: rtl/coef_arb_pkg.sv
package coef_arb_pkg;
   localparam int CTL_W     = 3;
   localparam int BIT_SWAP  = 0;
   localparam int BIT_ACT   = 1;
   localparam int BIT_ADAPT = 2;

   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_e;

   typedef struct packed {
      logic  ok;
      bank_e bank;
   } route_t;
endpackage

// File: rtl/coef_bank_store.sv
module coef_bank_store #(
   parameter int WORD_W = 24,
   parameter int DEPTH  = 128,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_h,
   input  logic [IDX_W-1:0]  raddr_e,
   output logic [WORD_W-1:0] rdata_h,
   output logic [WORD_W-1:0] rdata_e
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_h = mem[raddr_h];
   assign rdata_e = mem[raddr_e];
endmodule

// File: rtl/coef_arb_ctl.sv
module coef_arb_ctl
   import coef_arb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eng_on,
   input  logic             frame_tick,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             adapt,
   output logic             active,
   output logic             pending,
   output logic [CTL_W-1:0] ctl_rdata
);
   logic accept_req;
   logic do_swap;

   assign accept_req = ctl_we && ctl_wdata[BIT_SWAP] && adapt && eng_on && !pending;
   assign do_swap    = pending && frame_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adapt   <= 1'b0;
         active  <= 1'b0;
         pending <= 1'b0;
      end else begin
         if (ctl_we && !eng_on) adapt <= ctl_wdata[BIT_ADAPT];
         if (do_swap) begin
            active  <= ~active;
            pending <= 1'b0;
         end else if (accept_req) begin
            pending <= 1'b1;
         end
      end
   end

   always_comb begin
      ctl_rdata            = '0;
      ctl_rdata[BIT_ADAPT] = adapt;
      ctl_rdata[BIT_ACT]   = active;
      ctl_rdata[BIT_SWAP]  = pending;
   end

   // R7: a pending swap at a strobe flips the bank and clears itself
   a_r7_swap_completes: assert property (@(posedge clk) disable iff (!rst_n)
      pending && frame_tick |=> (active != $past(active)) && !pending);
   // R7/R9: the bank never changes without a pending request and a strobe
   a_r9_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(pending && frame_tick) |=> $stable(active));
   // R4: mode bit frozen while the engine runs
   a_r4_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      eng_on |=> $stable(adapt));
   // R11: no request is taken outside ping-pong operation
   a_r11_no_idle_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(adapt && eng_on) && !pending |=> !pending);
endmodule

// File: rtl/coef_arb_route.sv
module coef_arb_route
   import coef_arb_pkg::*;
(
   input  logic   adapt,
   input  logic   eng_on,
   input  logic   active,
   input  logic   host_win,
   input  logic   eng_msb,
   output route_t host_rt,
   output route_t eng_rt
);
   always_comb begin
      if (!eng_on) begin
         host_rt.ok   = 1'b1;
         host_rt.bank = bank_e'(host_win);
         eng_rt.ok    = 1'b0;
         eng_rt.bank  = bank_e'(eng_msb);
      end else if (adapt) begin
         host_rt.ok   = 1'b1;
         host_rt.bank = bank_e'(~active);
         eng_rt.ok    = 1'b1;
         eng_rt.bank  = bank_e'(active);
      end else begin
         host_rt.ok   = 1'b0;
         host_rt.bank = bank_e'(host_win);
         eng_rt.ok    = 1'b1;
         eng_rt.bank  = bank_e'(eng_msb);
      end
   end
endmodule

// File: rtl/coef_bank_arbiter.sv
module coef_bank_arbiter
   import coef_arb_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int BANK_DEPTH = 128,
   localparam int IDX_W     = $clog2(BANK_DEPTH),
   localparam int NBANK     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_on,
   input  logic              frame_tick,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              cf_we,
   input  logic              cf_win,
   input  logic [IDX_W-1:0]  cf_idx,
   input  logic [WORD_W-1:0] cf_wdata,
   output logic [WORD_W-1:0] cf_rdata,
   input  logic [IDX_W:0]    eng_addr,
   output logic [WORD_W-1:0] eng_rdata
);
   if (WORD_W < 1) begin : g_bad_width
      $error("WORD_W must be positive");
   end
   if (BANK_DEPTH < 2 || (1 << IDX_W) != BANK_DEPTH) begin : g_bad_depth
      $error("BANK_DEPTH must be a power of two of at least 2");
   end

   logic   adapt, active, pending;
   route_t host_rt, eng_rt;
   logic [WORD_W-1:0] h_rd [NBANK];
   logic [WORD_W-1:0] e_rd [NBANK];

   coef_arb_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .eng_on    (eng_on),
      .frame_tick(frame_tick),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .adapt     (adapt),
      .active    (active),
      .pending   (pending),
      .ctl_rdata (ctl_rdata)
   );

   coef_arb_route u_route (
      .adapt   (adapt),
      .eng_on  (eng_on),
      .active  (active),
      .host_win(cf_win),
      .eng_msb (eng_addr[IDX_W]),
      .host_rt (host_rt),
      .eng_rt  (eng_rt)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic BSEL = 1'(b);
      logic bank_we;
      assign bank_we = cf_we && host_rt.ok && (logic'(host_rt.bank) == BSEL);

      coef_bank_store #(
         .WORD_W(WORD_W),
         .DEPTH (BANK_DEPTH)
      ) u_store (
         .clk    (clk),
         .we     (bank_we),
         .waddr  (cf_idx),
         .wdata  (cf_wdata),
         .raddr_h(cf_idx),
         .raddr_e(eng_addr[IDX_W-1:0]),
         .rdata_h(h_rd[b]),
         .rdata_e(e_rd[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cf_rdata  <= '0;
         eng_rdata <= '0;
      end else begin
         cf_rdata  <= host_rt.ok ? h_rd[host_rt.bank] : '0;
         eng_rdata <= eng_rt.ok  ? e_rd[eng_rt.bank]  : '0;
      end
   end

   // R3: host reads are blanked while the engine owns the merged space
   a_r3_host_blanked: assert property (@(posedge clk) disable iff (!rst_n)
      !adapt && eng_on |=> cf_rdata == '0);
   // R2/R5: a disabled engine sees only zero
   a_r2_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_on |=> eng_rdata == '0);
   // R6: host and engine never share a bank in ping-pong operation
   a_r6_banks_split: assert property (@(posedge clk) disable iff (!rst_n)
      adapt && eng_on |-> host_rt.bank != eng_rt.bank);
endmodule

// File: tb/coef_bank_arbiter_tb.sv
`timescale 1ns/1ps
module coef_bank_arbiter_tb;
   localparam int W  = 24;
   localparam int D  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eng_on = 1'b0, frame_tick = 1'b0, ctl_we = 1'b0, cf_we = 1'b0, cf_win = 1'b0;
   logic [2:0]    ctl_wdata = '0;
   logic [2:0]    ctl_rdata;
   logic [IW-1:0] cf_idx = '0;
   logic [W-1:0]  cf_wdata = '0;
   logic [W-1:0]  cf_rdata, eng_rdata;
   logic [IW:0]   eng_addr = '0;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   coef_bank_arbiter #(.WORD_W(W), .BANK_DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .eng_on(eng_on), .frame_tick(frame_tick),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cf_we(cf_we), .cf_win(cf_win), .cf_idx(cf_idx), .cf_wdata(cf_wdata),
      .cf_rdata(cf_rdata), .eng_addr(eng_addr), .eng_rdata(eng_rdata)
   );

   function automatic logic [W-1:0] pat(int bank, int idx, int salt);
      return W'(salt * 24'h010000 + bank * 24'h001000 + idx * 7 + 1);
   endfunction

   task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic host_wr(int win, int idx, logic [W-1:0] d);
      @(negedge clk);
      cf_we = 1'b1; cf_win = 1'(win); cf_idx = IW'(idx); cf_wdata = d;
      @(negedge clk);
      cf_we = 1'b0;
   endtask

   task automatic host_rd(int win, int idx, output logic [W-1:0] d);
      @(negedge clk);
      cf_win = 1'(win); cf_idx = IW'(idx);
      @(negedge clk);
      d = cf_rdata;
   endtask

   task automatic eng_rd(int addr, output logic [W-1:0] d);
      @(negedge clk);
      eng_addr = (IW+1)'(addr);
      @(negedge clk);
      d = eng_rdata;
   endtask

   task automatic ctl_wr(logic [2:0] v, bit with_tick);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v; frame_tick = with_tick;
      @(negedge clk);
      ctl_we = 1'b0; frame_tick = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   task automatic power(bit v);
      @(negedge clk);
      eng_on = v;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset control", W'(ctl_rdata), 24'h0);

      // R2: merged mode, engine off
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) host_wr(b, i, pat(b, i, 1));
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R2 host readback", d, pat(b, i, 1));
         end
      for (int a = 0; a < 2*D; a++) begin
         eng_rd(a, d); chk("R2 engine blanked", d, 24'h0);
      end

      // R3: merged mode, engine on
      power(1'b1);
      for (int a = 0; a < 2*D; a++) begin
         eng_rd(a, d); chk("R3 engine merged read", d, pat(a / D, a % D, 1));
      end
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R3 host blanked", d, 24'h0);
            host_wr(b, i, pat(b, i, 2));
         end
      ctl_wr(3'b100, 0);
      chk("R4 mode write ignored while on", W'(ctl_rdata), 24'h0);
      ctl_wr(3'b001, 0);
      chk("R11 swap ignored in merged mode", W'(ctl_rdata), 24'h0);
      power(1'b0);
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R3 blocked writes had no effect", d, pat(b, i, 1));
         end

      // R4/R5: ping-pong mode, engine off
      ctl_wr(3'b100, 0);
      chk("R4 mode set while off", W'(ctl_rdata), 24'h4);
      ctl_wr(3'b101, 0);
      chk("R11 swap ignored while off", W'(ctl_rdata), 24'h4);
      for (int i = 0; i < D; i++) begin
         host_wr(0, i, pat(0, i, 3));
         host_wr(1, i, pat(1, i, 4));
      end
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R5 window to own bank", d, pat(b, i, 3 + b));
         end
      for (int a = 0; a < 2*D; a++) begin
         eng_rd(a, d); chk("R5 engine blanked", d, 24'h0);
      end

      // R6/R10: ping-pong mode, engine on
      power(1'b1);
      chk("R10 first bank is A", W'(ctl_rdata), 24'h4);
      for (int a = 0; a < 2*D; a++) begin
         eng_rd(a, d); chk("R10 R6 engine reads bank A", d, pat(0, a % D, 3));
      end
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R6 host sees idle bank B", d, pat(1, i, 4));
         end
      for (int i = 0; i < D; i++) host_wr(i % 2, i, pat(1, i, 5));
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R6 windows alias", d, pat(1, i, 5));
         end
      eng_rd(3, d); chk("R6 engine unaffected", d, pat(0, 3, 3));

      // R7/R8/R9: swap
      ctl_wr(3'b001, 0);
      chk("R7 request pending", W'(ctl_rdata), 24'h5);
      repeat (20) @(negedge clk);
      chk("R8 stays pending without strobes", W'(ctl_rdata), 24'h5);
      ctl_wr(3'b001, 0);
      chk("R9 re-request keeps state", W'(ctl_rdata), 24'h5);
      tick();
      chk("R7 swap done", W'(ctl_rdata), 24'h6);
      tick();
      chk("R9 only one bank change", W'(ctl_rdata), 24'h6);
      for (int a = 0; a < 2*D; a++) begin
         eng_rd(a, d); chk("R7 engine now bank B", d, pat(1, a % D, 5));
      end
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++) begin
            host_rd(b, i, d); chk("R7 host now bank A", d, pat(0, i, 3));
         end
      ctl_wr(3'b001, 1);
      chk("R8 request with strobe waits", W'(ctl_rdata), 24'h7);
      tick();
      chk("R8 swap at next strobe", W'(ctl_rdata), 24'h4);
      eng_rd(5, d); chk("R8 engine back on bank A", d, pat(0, 5, 3));
      ctl_wr(3'b000, 0);
      chk("R4 mode clear ignored while on", W'(ctl_rdata), 24'h4);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule